// File: doc/BRIEF.md
# Serial Register Access Master

This block drives a four-wire serial link to a touch sensor controller whose registers have 5-bit addresses. A single request on its command port becomes one complete chip-select frame on the link. The frame can be a write of one or more address/data pairs, a read of a single register, or a burst read of up to `MAX_CNT` consecutive registers. The block builds each command byte from the register address. It pads reads with the controller's filler codes, drops the three dummy bytes that every read returns first, and passes each data byte back with a one-cycle valid strobe.

The link runs with the clock idling low. Data leaves on the rising clock edge and is captured on the falling edge, most significant bit first. The serial clock is the system clock divided by `2*HALF_DIV`. Software-side code issues one request, waits for `done_o`, and collects read bytes as `rvalid_o` strobes arrive.

Top module: `spi_reg_master`

## Requirements
- R1: Every command byte carries the 5-bit register address in bits 4:0 and sets bit 7. Bit 5 is set for a read (0xA0|addr) and clear for a write (0x80|addr). Bit 6 is always clear.
- R2: A write (op_i=2'b00) with cnt_i=k sends, inside one chip-select frame, k pairs back to back. Each pair is the write command for addr_i slot i followed by wdata_i slot i, so the frame is 2k bytes. cnt_i=0 sends one pair, and a count above MAX_CNT sends MAX_CNT pairs.
- R3: A single read (op_i=2'b01) sends the read command for addr_i slot 0 followed by three 0xFB bytes. The first three received bytes are dropped, and the fourth appears on rdata_o with exactly one rvalid_o strobe.
- R4: A burst read (op_i[1]=1) of length N sends the read command, then N+1 bytes of 0xFC, then one 0xFB, for N+3 bytes in total. Received bytes 4 to N+3 are presented in order as N rvalid_o strobes.
- R5: For a burst, cnt_i=0 gives N=1, and a cnt_i above MAX_CNT gives N=MAX_CNT.
- R6: sclk_o is low whenever cs_no is high. mosi_o changes only on a rising sclk_o edge, miso_i is sampled on the falling edge, and bytes go out and come in MSB first.
- R7: With HALF_DIV of 2 or more, every sclk_o period within a frame is 2*HALF_DIV clock cycles. cs_no stays high for at least 2*HALF_DIV cycles between frames.
- R8: busy_o is high from the accepted request until the frame and its trailing gap end. done_o pulses for one cycle per frame. A request made while busy_o is high is ignored.
- R9: cs_no is low only while busy_o is high. rvalid_o never pulses during a write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a frame (accepted while idle) |
| op_i | input | 2 | 00 write, 01 single read, 1x burst read |
| cnt_i | input | CNT_W | Write pair count or burst length |
| addr_i | input | 5*MAX_CNT | Register address per slot, slot 0 in bits 4:0 |
| wdata_i | input | 8*MAX_CNT | Write data per slot, slot 0 in bits 7:0 |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| rdata_o | output | 8 | Read data byte |
| rvalid_o | output | 1 | rdata_o valid strobe |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench builds the block with HALF_DIV=2 and MAX_CNT=8. This gives a four-cycle serial clock, so period and chip-select gap measurements are exact integers, and the registered byte-done path is exercised at its tightest legal divider. MAX_CNT=8 with a 4-bit count field reaches the full eight-byte burst, the clamp for counts of 9 to 15, and a write of eight back-to-back pairs. A bus-slave model with an address-derived register image checks byte order and the dropping of the dummy bytes across an address wrap at 0x1F.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;
  localparam logic [7:0] CMD_RD   = 8'hA0;
  localparam logic [7:0] CMD_WR   = 8'h80;
  localparam logic [7:0] FILL_END = 8'hFB;
  localparam logic [7:0] FILL_INC = 8'hFC;
  localparam int DUMMY_N   = 3;
  localparam int GAP_TICKS = 3;
  localparam logic [1:0] OP_WR = 2'b00;
  localparam logic [1:0] OP_RD = 2'b01;
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_XFER, ST_GAP} state_e;
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift
  import spi_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] tx_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [BYTE_W-1:0] rx_o,
  output logic              done_o
);
  localparam int EDGES = 2 * BYTE_W;
  localparam int EW    = $clog2(EDGES);

  logic              active_q;
  logic [EW-1:0]     edge_q;
  logic [BYTE_W-1:0] tx_q, rx_q;

  assign rx_o = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      edge_q   <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      sclk_o   <= 1'b0;
      mosi_o   <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        edge_q   <= '0;
        tx_q     <= tx_i;
      end else if (active_q && tick_i) begin
        edge_q <= edge_q + 1'b1;
        if (!edge_q[0]) begin
          // leading edge: launch next bit
          sclk_o <= 1'b1;
          mosi_o <= tx_q[BYTE_W-1];
          tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
        end else begin
          // trailing edge: capture
          sclk_o <= 1'b0;
          rx_q   <= {rx_q[BYTE_W-2:0], miso_i};
          if (edge_q == EW'(EDGES - 1)) begin
            active_q <= 1'b0;
            done_o   <= 1'b1;
          end
        end
      end
    end
  end

  p_mosi_on_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mosi_o) |-> $rose(sclk_o));
  p_sclk_low_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !sclk_o);
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int MAX_CNT  = 8,
  localparam int CNT_W   = $clog2(MAX_CNT + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic [1:0]                op_i,
  input  logic [CNT_W-1:0]          cnt_i,
  input  logic [ADDR_W*MAX_CNT-1:0] addr_i,
  input  logic [BYTE_W*MAX_CNT-1:0] wdata_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [BYTE_W-1:0]         rdata_o,
  output logic                      rvalid_o,
  output logic                      sclk_o,
  output logic                      cs_no,
  output logic                      mosi_o,
  input  logic                      miso_i
);
  localparam int IDX_W  = $clog2(2 * MAX_CNT + 4);
  localparam int PAIR_W = $clog2(MAX_CNT);

  state_e            state_q;
  logic [1:0]        op_q;
  logic [CNT_W-1:0]  n_q, n_eff;
  logic [IDX_W-1:0]  idx_q, last_q, last_n, nk;
  logic [1:0]        gap_q;
  logic [ADDR_W-1:0] addr_q [MAX_CNT];
  logic [BYTE_W-1:0] data_q [MAX_CNT];
  logic              tick, sh_start, sh_done;
  logic [BYTE_W-1:0] sh_tx, sh_rx;
  logic [PAIR_W-1:0] pair;
  logic              is_wr, is_rd, is_last;

  assign is_wr   = (op_q == OP_WR);
  assign is_rd   = (op_q == OP_RD);
  assign is_last = (idx_q == last_q);
  assign busy_o  = (state_q != ST_IDLE);

  // clamp count: 0 -> 1, above MAX_CNT -> MAX_CNT
  always_comb begin
    if (cnt_i == '0)                      n_eff = CNT_W'(1);
    else if (cnt_i > CNT_W'(MAX_CNT))     n_eff = CNT_W'(MAX_CNT);
    else                                  n_eff = cnt_i;
    if (op_i == OP_WR)      last_n = (IDX_W'(n_eff) << 1) - 1'b1;
    else if (op_i == OP_RD) last_n = IDX_W'(DUMMY_N);
    else                    last_n = IDX_W'(n_eff) + IDX_W'(DUMMY_N - 1);
  end

  // byte to launch next, derived from its frame position
  always_comb begin
    nk   = (state_q == ST_LEAD) ? '0 : idx_q + 1'b1;
    pair = nk[PAIR_W:1];
    if (is_wr)
      sh_tx = nk[0] ? data_q[pair] : (CMD_WR | BYTE_W'(addr_q[pair]));
    else if (nk == '0)
      sh_tx = CMD_RD | BYTE_W'(addr_q[0]);
    else if (is_rd || nk == last_q)
      sh_tx = FILL_END;
    else
      sh_tx = FILL_INC;
  end

  assign sh_start = (state_q == ST_LEAD && tick) ||
                    (state_q == ST_XFER && sh_done && !is_last);

  spi_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  spi_byte_shift u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .start_i(sh_start),
    .tx_i   (sh_tx),
    .miso_i (miso_i),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o),
    .rx_o   (sh_rx),
    .done_o (sh_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_WR;
      n_q      <= '0;
      idx_q    <= '0;
      last_q   <= '0;
      gap_q    <= '0;
      cs_no    <= 1'b1;
      done_o   <= 1'b0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
      for (int i = 0; i < MAX_CNT; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      done_o   <= 1'b0;
      rvalid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q <= ST_LEAD;
          op_q    <= op_i;
          n_q     <= n_eff;
          last_q  <= last_n;
          idx_q   <= '0;
          cs_no   <= 1'b0;
          for (int i = 0; i < MAX_CNT; i++) begin
            addr_q[i] <= addr_i[i*ADDR_W +: ADDR_W];
            data_q[i] <= wdata_i[i*BYTE_W +: BYTE_W];
          end
        end
        ST_LEAD: if (tick) state_q <= ST_XFER;
        ST_XFER: if (sh_done) begin
          if (!is_wr && idx_q >= IDX_W'(DUMMY_N)) begin
            rvalid_o <= 1'b1;
            rdata_o  <= sh_rx;
          end
          if (is_last) begin
            state_q <= ST_GAP;
            cs_no   <= 1'b1;
            gap_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_GAP: if (tick) begin
          if (gap_q == 2'(GAP_TICKS - 1)) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // checker: read strobes per frame never exceed the requested count
  logic [CNT_W-1:0] rv_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rv_seen_q <= '0;
    else if (state_q == ST_IDLE && req_i) rv_seen_q <= '0;
    else if (rvalid_o)                    rv_seen_q <= rv_seen_q + 1'b1;
  end

  p_rvalid_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (rv_seen_q < (is_rd ? CNT_W'(1) : n_q)));
  p_rvalid_not_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> !is_wr);
  p_cs_in_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o);
  p_sclk_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_ends_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
endmodule

// File: tb/spi_reg_master_bench.sv
module spi_reg_master_bench;
  localparam int HALF = 2;
  localparam int MAXC = 8;
  localparam int CW   = $clog2(MAXC + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            req = 1'b0;
  logic [1:0]      op = '0;
  logic [CW-1:0]   cnt = '0;
  logic [5*MAXC-1:0] addrs = '0;
  logic [8*MAXC-1:0] wdata = '0;
  logic busy, done, rvalid, sclk, cs_n, mosi;
  logic miso = 1'b0;
  logic [7:0] rdata;

  spi_reg_master #(.HALF_DIV(HALF), .MAX_CNT(MAXC)) u_spi_reg_master (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .cnt_i(cnt),
    .addr_i(addrs), .wdata_i(wdata), .busy_o(busy), .done_o(done),
    .rdata_o(rdata), .rvalid_o(rvalid), .sclk_o(sclk), .cs_no(cs_n),
    .mosi_o(mosi), .miso_i(miso)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave model: drives on rising sclk, captures on falling sclk
  logic [7:0] sb [64];
  logic [7:0] s_in = '0, s_out = '0;
  logic [4:0] s_addr = '0;
  int sk = 0, sbit = 0, frames = 0;

  function automatic logic [7:0] mem_val(input logic [4:0] a);
    return {3'b0, a} * 8'd7 + 8'h11;
  endfunction

  always @(negedge cs_n) begin
    sk = 0; sbit = 0; s_out = 8'hEE; frames++;
  end
  always @(posedge sclk) if (!cs_n) begin
    miso = s_out[7];
    s_out = {s_out[6:0], 1'b0};
  end
  always @(negedge sclk) if (!cs_n) begin
    s_in = {s_in[6:0], mosi};
    sbit++;
    if (sbit == 8) begin
      if (sk < 64) sb[sk] = s_in;
      if (sk == 0) s_addr = s_in[4:0];
      sk++;
      sbit = 0;
      s_out = (sk < 3) ? 8'hEE : mem_val(5'(s_addr + 5'(sk - 3)));
    end
  end

  // monitors
  logic [7:0] rv [64];
  int rv_n = 0, done_n = 0, idle_sclk = 0;
  int per_min = 1000, per_max = 0, gap_min = 1000, gap_cnt = 0, since_rise = 0;
  bit prev_sclk = 0, prev_cs = 1, rise_valid = 0, seen_frame = 0;

  always @(posedge clk) begin
    if (rvalid && rv_n < 64) begin rv[rv_n] = rdata; rv_n++; end
    if (done) done_n++;
    if (rst_n && cs_n && sclk) idle_sclk++;
    since_rise++;
    if (sclk && !prev_sclk) begin
      if (rise_valid) begin
        if (since_rise < per_min) per_min = since_rise;
        if (since_rise > per_max) per_max = since_rise;
      end
      rise_valid = 1; since_rise = 0;
    end
    if (cs_n) begin
      rise_valid = 0;
      gap_cnt++;
    end
    if (!cs_n && prev_cs) begin
      if (seen_frame && gap_cnt < gap_min) gap_min = gap_cnt;
      gap_cnt = 0;
    end
    if (cs_n && !prev_cs) seen_frame = 1;
    prev_sclk = sclk; prev_cs = cs_n;
  end

  logic [7:0] eb [64];
  int f0;

  task automatic go(input logic [1:0] o, input int c, input logic [4:0] a0);
    @(negedge clk);
    rv_n = 0; done_n = 0; f0 = frames;
    op = o; cnt = CW'(c); addrs[4:0] = a0; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_frame(input string tag, input int nb, input int nrv);
    chk(frames == f0 + 1, {tag, " one frame"}, frames - f0, 1);
    chk(sk == nb, {tag, " byte count"}, sk, nb);
    for (int i = 0; i < nb && i < sk; i++)
      chk(sb[i] == eb[i], {tag, " tx byte"}, sb[i], eb[i]);
    chk(rv_n == nrv, {tag, " rvalid count"}, rv_n, nrv);
    chk(done_n == 1, {tag, " done pulses R8"}, done_n, 1);
    chk(!busy, {tag, " busy low R8"}, busy, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !rvalid, "R8 reset idle", {busy, done, rvalid}, 0);
    chk(cs_n && !sclk, "R9 reset cs/sclk", {cs_n, sclk}, 2);
  endtask

  task automatic t_write_single;
    wdata[7:0] = 8'h3C;
    eb[0] = 8'h85; eb[1] = 8'h3C;
    go(2'b00, 1, 5'h05);
    check_frame("R1 R2 write single", 2, 0);
  endtask

  task automatic t_write_seq;
    for (int i = 0; i < MAXC; i++) begin
      addrs[i*5 +: 5] = 5'(3 * i + 1);
      wdata[i*8 +: 8] = 8'(8'hA1 + 17 * i);
    end
    for (int i = 0; i < 3; i++) begin
      eb[2*i]   = 8'h80 | 8'(3 * i + 1);
      eb[2*i+1] = 8'(8'hA1 + 17 * i);
    end
    go(2'b00, 3, 5'h01);
    check_frame("R2 write three pairs", 6, 0);
    for (int i = 0; i < MAXC; i++) begin
      eb[2*i]   = 8'h80 | 8'(3 * i + 1);
      eb[2*i+1] = 8'(8'hA1 + 17 * i);
    end
    go(2'b00, 15, 5'h01);
    check_frame("R2 write clamp to max", 2 * MAXC, 0);
    eb[0] = 8'h81; eb[1] = 8'hA1;
    go(2'b00, 0, 5'h01);
    check_frame("R2 write zero count", 2, 0);
  endtask

  task automatic t_read_single;
    eb[0] = 8'hBF; eb[1] = 8'hFB; eb[2] = 8'hFB; eb[3] = 8'hFB;
    go(2'b01, 5, 5'h1F);
    check_frame("R1 R3 single read", 4, 1);
    chk(rv[0] == mem_val(5'h1F), "R3 read value", rv[0], mem_val(5'h1F));
  endtask

  task automatic burst(input string tag, input logic [1:0] o, input int c,
                       input int n, input logic [4:0] a);
    eb[0] = 8'hA0 | {3'b0, a};
    for (int i = 1; i <= n + 1; i++) eb[i] = 8'hFC;
    eb[n + 2] = 8'hFB;
    go(o, c, a);
    check_frame(tag, n + 3, n);
    for (int i = 0; i < n && i < rv_n; i++)
      chk(rv[i] == mem_val(5'(a + 5'(i))), {tag, " data"}, rv[i], mem_val(5'(a + 5'(i))));
  endtask

  task automatic t_bursts;
    burst("R4 burst six", 2'b10, 6, 6, 5'h12);
    burst("R5 burst zero", 2'b11, 0, 1, 5'h07);
    burst("R5 burst clamp", 2'b10, 12, MAXC, 5'h1C);
  endtask

  task automatic t_timing;
    per_min = 1000; per_max = 0; gap_min = 1000;
    burst("R7 timing frame a", 2'b10, 4, 4, 5'h02);
    burst("R7 timing frame b", 2'b10, 2, 2, 5'h09);
    chk(per_min == 2 * HALF, "R7 sclk period min", per_min, 2 * HALF);
    chk(per_max == 2 * HALF, "R7 sclk period max", per_max, 2 * HALF);
    chk(gap_min >= 2 * HALF, "R7 cs gap", gap_min, 2 * HALF);
    chk(idle_sclk == 0, "R6 sclk idle low", idle_sclk, 0);
  endtask

  task automatic t_ignore;
    eb[0] = 8'hA4;
    for (int i = 1; i <= 4; i++) eb[i] = 8'hFC;
    eb[5] = 8'hFB;
    @(negedge clk);
    rv_n = 0; done_n = 0; f0 = frames;
    op = 2'b10; cnt = CW'(3); addrs[4:0] = 5'h04; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (6) @(negedge clk);
    op = 2'b00; cnt = CW'(1); addrs[4:0] = 5'h15; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (!done) @(negedge clk);
    repeat (20) @(negedge clk);
    check_frame("R8 request while busy ignored", 6, 3);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_write_single;
    t_write_seq;
    t_read_single;
    t_bursts;
    t_timing;
    t_ignore;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule